// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It reads each instruction through a combinational instruction port, decodes it and reads two source registers. The core then computes an ALU result, a memory address or a next-PC value, and commits the result on the next rising clock edge. The supported set is seven register-to-register operations (add, subtract, and, or, xor, nor, set-less-than), word load, word store, branch-if-equal and an absolute jump.

The instruction store lives outside the core and is read combinationally at the address on `imem_addr`. The data memory is a small word array inside the core: reads are combinational and writes are synchronous. Every store is also visible at the top ports as an address, a data word and a write strobe, so that a surrounding system or a testbench can see what is written. Separate adders produce PC+4 and the branch target, so nothing in the datapath is shared within a cycle.

Top module: `sc_cpu`

## Requirements
- R1: While `rst_n` is low at a rising edge the PC becomes 0. `dmem_we` stays low while `rst_n` is low, even when the instruction at address 0 is a store.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by 4 at the next rising edge.
- R3: Opcode bits 31-26 = 000000 selects a register operation on rs (bits 25-21) and rt (bits 20-16), written to rd (bits 15-11). Function field bits 5-0 pick the operation: 100000 add, 100010 subtract (rs-rt), 100100 and, 100101 or, 100110 xor, 100111 nor.
- R4: Function code 101010 writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: Register 0 always reads as zero, and any write aimed at it is discarded.
- R6: Opcode 101011 (store) drives `dmem_we` high for that cycle, with `dmem_addr` = rs + sign-extended bits 15-0 and `dmem_wdata` = rt. The word is written at the next rising edge.
- R7: Opcode 100011 (load) writes the data word at rs + sign-extended bits 15-0 into rt (bits 20-16), and the value is visible to the following instruction.
- R8: Opcode 000100 (branch) compares rs and rt. When they are equal the next PC is PC+4 plus the sign-extended bits 15-0 shifted left by 2, forward or backward. Otherwise the next PC is PC+4.
- R9: Opcode 000010 (jump) sets the next PC to bits 31-28 of PC+4 followed by instruction bits 25-0 and two zero bits.
- R10: `dmem_we` is low for every instruction that is not a store, including register operations, loads, branches and jumps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, supplied combinationally |
| dmem_we | output | 1 | High during a cycle that stores a word |
| dmem_addr | output | 32 | Byte address computed by the ALU for loads and stores |
| dmem_wdata | output | 32 | Data word written by a store |

## Verification
The store bus outputs are combinational from the current instruction, so they are due in the same cycle that the store's address sits on `imem_addr`. A new PC is due one rising edge after its instruction, and a register or memory write is due one edge after its producer, so it is seen by the next instruction. The bench drives reset and samples every output at the falling edge. After each falling edge it advances by exactly one rising edge per instruction and compares the PC and the store bus with values worked out by hand for that position in the program. Register contents are brought out by later stores, so each store check also covers the arithmetic, load, register-0 and signed-compare results that produced the stored word.

// File: rtl/sc_pkg.sv
// Shared types for the single-cycle core: opcode values, the ALU
// operation encoding, the ALU class passed from the main decoder, and
// the bundle of datapath control bits.
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_XOR = 6'b100110;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_XOR = 4'b0010,
        ALU_NOR = 4'b0011,
        ALU_ADD = 4'b0110,
        ALU_SUB = 4'b1110,
        ALU_SLT = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef struct packed {
        logic     dst_rd;
        logic     src_imm;
        logic     wb_mem;
        logic     reg_we;
        logic     mem_we;
        logic     is_branch;
        logic     is_jump;
        alu_cls_e alu_cls;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
// Two-level decoder. The main level turns the opcode into datapath
// controls and an ALU class; the second level turns the class and the
// function field into a 4-bit ALU operation. Assumes an unknown opcode
// should act as a no-operation (no register or memory write, PC+4).
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_op_e    alu_op
);

    // Main decode: opcode to datapath controls.
    always_comb begin
        ctl = '0;
        ctl.alu_cls = CLS_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctl.dst_rd  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.alu_cls = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.reg_we  = 1'b1;
            end
            OPC_STORE: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.alu_cls   = CLS_SUB;
            end
            OPC_JUMP: begin
                ctl.is_jump = 1'b1;
            end
            default: ;
        endcase
    end

    // Second-level decode: class and function field to ALU operation.
    always_comb begin
        alu_op = ALU_ADD;
        unique case (ctl.alu_cls)
            CLS_SUB: alu_op = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_XOR:  alu_op = ALU_XOR;
                    FN_NOR:  alu_op = ALU_NOR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: alu_op = ALU_ADD;
                endcase
            end
            default: alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// General register file with two combinational read ports and one write
// port that commits on the rising edge. Entry 0 is never written, so it
// reads as zero. Assumes a synchronous active-low reset that clears all.
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] regs [NREGS];

    // Clear on reset, else commit a write unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Combinational read ports.
    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    // R5: a write aimed at entry 0 leaves it at zero.
    a_r5_zero_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa == '0)) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_alu.sv
// Combinational ALU over the seven operations of the 4-bit encoding.
// The compare is signed two's-complement. Also flags a zero result.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Operation select.
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOR: y = ~(a | b);
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_dmem.sv
// Word-addressed data memory: combinational read, write on the rising
// edge. Byte address bits 1:0 are ignored and addresses wrap at the
// depth. Assumes a synchronous active-low reset that clears the array.
module sc_dmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] wd,
    output logic [W-1:0] rd
);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] idx;
    logic          unused_addr_bits;

    assign idx = addr[IW+1:2];
    assign unused_addr_bits = ^{addr[W-1:IW+2], addr[1:0]};

    // Clear on reset, else store the word on a write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wd;
        end
    end

    // Combinational read.
    assign rd = mem[idx];

endmodule

// File: rtl/sc_cpu.sv
// Single-cycle core top. Holds the PC and the next-PC selection, and
// joins the decoder, register file, ALU and data memory. The instruction
// is read combinationally from outside at the PC; every store is also
// driven out on the dmem_* ports. Assumes a synchronous active-low
// reset; the PC restarts at 0.
module sc_cpu
    import sc_pkg::*;
#(
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic        dmem_we,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata
);

    localparam int RAW = $clog2(NREGS);

    logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] imm_sext, rs_val, rt_val, alu_b, alu_y, ld_data, wb_data;
    logic [RAW-1:0]  wr_addr;
    logic            alu_zero;
    ctrl_t           ctl;
    alu_op_e         alu_op;
    logic            unused_shamt;

    assign unused_shamt = ^imem_rdata[10:6];

    sc_ctrl u_ctrl (
        .opcode (imem_rdata[31:26]),
        .funct  (imem_rdata[5:0]),
        .ctl    (ctl),
        .alu_op (alu_op)
    );

    assign imm_sext = {{16{imem_rdata[15]}}, imem_rdata[15:0]};
    assign wr_addr  = ctl.dst_rd ? imem_rdata[15:11] : imem_rdata[20:16];

    sc_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (imem_rdata[25:21]),
        .ra_b  (imem_rdata[20:16]),
        .we    (ctl.reg_we),
        .wa    (wr_addr),
        .wd    (wb_data),
        .rd_a  (rs_val),
        .rd_b  (rt_val)
    );

    assign alu_b = ctl.src_imm ? imm_sext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_dmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dmem_we),
        .addr  (alu_y),
        .wd    (rt_val),
        .rd    (ld_data)
    );

    assign wb_data = ctl.wb_mem ? ld_data : alu_y;

    // Separate adders for the sequential and branch targets.
    assign pc_plus4   = pc + 32'd4;
    assign br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};

    // Next-PC select: jump, taken branch, or sequential.
    always_comb begin
        if (ctl.is_jump)                    pc_next = jmp_target;
        else if (ctl.is_branch && alu_zero) pc_next = br_target;
        else                                pc_next = pc_plus4;
    end

    // PC register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign imem_addr  = pc;
    assign dmem_we    = ctl.mem_we & rst_n;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;

    // R1: reset forces the PC to zero.
    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == 32'd0));

    // R2: sequential instructions advance by one word.
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] != OPC_JUMP && imem_rdata[31:26] != OPC_BEQ)
        |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R8: an equal compare on a branch lands on the offset target.
    a_r8_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] == OPC_BEQ && rs_val == rt_val)
        |=> (imem_addr == $past(imem_addr) + 32'd4
                          + {$past(imm_sext[XLEN-3:0]), 2'b00}));

    // R9: a jump replaces the low 28 bits with the shifted index.
    a_r9_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[31:26] == OPC_JUMP)
        |=> (imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}));

    // R10: the store strobe appears only for a store opcode.
    a_r10_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (imem_rdata[31:26] == OPC_STORE));

endmodule

// File: tb/tb_sc_cpu.sv
`timescale 1ns/1ps
module tb_sc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata;
    logic        dmem_we;
    logic [31:0] rom [64];
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    assign imem_rdata = rom[imem_addr[7:2]];

    sc_cpu dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata)
    );

    function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'b000010, idx[25:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_store(input string tag, input logic [31:0] a, input logic [31:0] d);
        chk({tag, " R6 we"}, {31'd0, dmem_we}, 32'd1);
        chk({tag, " R6 addr"}, dmem_addr, a);
        chk({tag, " data"}, dmem_wdata, d);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 64; i++) rom[i] = 32'd0;
    endtask

    task automatic reset_go();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.1;
    endtask

    // Common prefix: r1=-1, r2=1, r3=2, r4=4, r5=5.
    task automatic load_consts();
        rom[0] = enc_r(1, 0, 0, 6'b100111);
        rom[1] = enc_r(2, 0, 1, 6'b100010);
        rom[2] = enc_r(3, 2, 2, 6'b100000);
        rom[3] = enc_r(4, 3, 3, 6'b100000);
        rom[4] = enc_r(5, 4, 2, 6'b100000);
    endtask

    // R1: PC and store strobe under reset, and reset during a run.
    task automatic t_reset();
        clear_rom();
        rom[0] = enc_i(6'b101011, 0, 0, 4);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'd0);
        chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        rst_n = 1'b1;
        #0.1;
        chk_store("R1 store after release", 32'd4, 32'd0);
        step(); step(); step();
        chk("R2 pc runs", imem_addr, 32'd12);
        rst_n = 1'b0;
        step();
        chk("R1 mid-run reset pc", imem_addr, 32'd0);
    endtask

    // R3 R4 R5 R10: register operations then stores of each result.
    task automatic t_alu();
        logic [31:0] ea [10];
        logic [31:0] ed [10];
        string       tg [10];
        clear_rom();
        load_consts();
        rom[5]  = enc_r(6, 3, 5, 6'b100010);
        rom[6]  = enc_r(7, 5, 6, 6'b100100);
        rom[7]  = enc_r(8, 3, 5, 6'b100101);
        rom[8]  = enc_r(9, 5, 4, 6'b100110);
        rom[9]  = enc_r(10, 6, 2, 6'b101010);
        rom[10] = enc_r(11, 2, 6, 6'b101010);
        rom[11] = enc_r(0, 5, 5, 6'b100000);
        rom[12] = enc_r(12, 5, 3, 6'b100111);
        ea = '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36};
        ed = '{32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFD, 32'd5, 32'd7,
               32'd1, 32'd1, 32'd0, 32'd0, 32'hFFFF_FFF8};
        tg = '{"R3 nor zero", "R3 sub", "R3 sub negative", "R3 and", "R3 or",
               "R3 xor", "R4 slt neg<pos", "R4 slt pos<neg", "R5 r0 write dropped", "R3 nor"};
        rom[13] = enc_i(6'b101011, 0, 1, 0);
        rom[14] = enc_i(6'b101011, 0, 2, 4);
        rom[15] = enc_i(6'b101011, 0, 6, 8);
        rom[16] = enc_i(6'b101011, 0, 7, 12);
        rom[17] = enc_i(6'b101011, 0, 8, 16);
        rom[18] = enc_i(6'b101011, 0, 9, 20);
        rom[19] = enc_i(6'b101011, 0, 10, 24);
        rom[20] = enc_i(6'b101011, 0, 11, 28);
        rom[21] = enc_i(6'b101011, 0, 0, 32);
        rom[22] = enc_i(6'b101011, 0, 12, 36);
        reset_go();
        for (int i = 0; i < 13; i++) begin
            chk("R2 pc sequential", imem_addr, 32'(4 * i));
            chk("R10 no store on reg op", {31'd0, dmem_we}, 32'd0);
            step();
        end
        for (int i = 0; i < 10; i++) begin
            chk_store(tg[i], ea[i], ed[i]);
            step();
        end
    endtask

    // R6 R7 R5: store, load back, negative offset, load into r0.
    task automatic t_mem();
        clear_rom();
        load_consts();
        rom[5]  = enc_i(6'b101011, 4, 5, 8);
        rom[6]  = enc_i(6'b100011, 4, 12, 8);
        rom[7]  = enc_i(6'b101011, 0, 12, 64);
        rom[8]  = enc_i(6'b101011, 4, 2, -4);
        rom[9]  = enc_i(6'b100011, 0, 13, 0);
        rom[10] = enc_i(6'b101011, 0, 13, 68);
        rom[11] = enc_i(6'b100011, 4, 0, 8);
        rom[12] = enc_i(6'b101011, 0, 0, 72);
        reset_go();
        repeat (5) step();
        chk_store("R6 base+offset", 32'd12, 32'd5);
        step();
        chk("R10 no store on load", {31'd0, dmem_we}, 32'd0);
        step();
        chk_store("R7 load then store", 32'd64, 32'd5);
        step();
        chk_store("R6 negative offset", 32'd0, 32'd1);
        step(); step();
        chk_store("R7 load of neg-offset word", 32'd68, 32'd1);
        step(); step();
        chk_store("R5 load into r0 dropped", 32'd72, 32'd0);
    endtask

    // R8 R9: not-taken, forward, backward branches and jumps.
    task automatic t_flow();
        clear_rom();
        rom[0]  = enc_r(1, 0, 0, 6'b100111);
        rom[1]  = enc_r(2, 0, 1, 6'b100010);
        rom[2]  = enc_r(3, 2, 2, 6'b100000);
        rom[3]  = enc_i(6'b000100, 2, 3, 5);
        rom[4]  = enc_i(6'b000100, 2, 2, 2);
        rom[5]  = enc_i(6'b101011, 0, 2, 0);
        rom[6]  = enc_i(6'b101011, 0, 2, 4);
        rom[7]  = enc_j(10);
        rom[9]  = enc_j(12);
        rom[10] = enc_i(6'b101011, 0, 3, 8);
        rom[11] = enc_i(6'b000100, 0, 0, -3);
        rom[12] = enc_i(6'b101011, 0, 2, 12);
        reset_go();
        step(); step(); step();
        chk("R2 pc before branch", imem_addr, 32'd12);
        step();
        chk("R8 not taken", imem_addr, 32'd16);
        chk("R10 no store on branch", {31'd0, dmem_we}, 32'd0);
        step();
        chk("R8 forward taken", imem_addr, 32'd28);
        step();
        chk("R9 jump forward", imem_addr, 32'd40);
        chk_store("R6 at jump target", 32'd8, 32'd2);
        step();
        chk("R2 pc after store", imem_addr, 32'd44);
        step();
        chk("R8 backward taken", imem_addr, 32'd36);
        step();
        chk("R9 jump", imem_addr, 32'd48);
        chk_store("R6 after jump", 32'd12, 32'd1);
        step();
        chk("R2 pc after final store", imem_addr, 32'd52);
    endtask

    initial begin
        clear_rom();
        t_reset();
        t_alu();
        t_mem();
        t_flow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule